// File: doc/BRIEF.md
# Programmable Pulse Train Channel

This block is one serial output channel that plays back a stored bit pattern. A shared bit-rate strobe (`tick`) sets the bit period: each strobe advances the channel by one bit time. In pattern mode the channel sends the low bits of its pattern register, least significant bit first. The number of bits sent comes from a length code. The pattern repeats either a programmed number of times or without end, and an optional idle gap, measured in bit times, separates one repetition from the next. In square-wave mode the channel ignores the pattern and drives a 50% duty clock whose half-period is a programmed number of strobes.

Software sets the channel up through a small write port while `enable` is low, and then raises `enable` to start it. Only the pattern register may be rewritten while the channel runs, so a live stream can be changed on the fly. When a finite repetition count is used up, the channel reports this with a single-clock `loop_exit` pulse. It then stays silent until `enable` is dropped and raised again.

Top module: `pulse_chan`

## Requirements
- R1: In pattern mode, the first tick after `enable` rises drives pattern bit 0 onto `dout`. Each later tick drives the next higher bit. `dout` is registered and changes only on a clock edge where `tick` is high.
- R2: Length code 0 (field `cfg_wdata[4:0]` at address 1) sends all 32 pattern bits. A code N from 2 to 31 sends bits 0 to N-1.
- R3: Writing length code 1 makes the channel send 2 bits and sets `len_err`. Writing any other length code clears `len_err`.
- R4: A loop count of 0 (address 2, `cfg_wdata[15:0]`) repeats the pattern forever. A count N>0 sends N repetitions. On the tick after the last bit of the last repetition, `dout` goes to 0 and `loop_exit` is high for exactly one clock. The channel then stays stopped with `dout` at 0 while `enable` remains high.
- R5: With loop delay D (address 3, `cfg_wdata[15:0]`), `dout` holds the last bit of a repetition for D further ticks before bit 0 of the next repetition is sent. D=0 sends the repetitions back to back.
- R6: In square-wave mode (address 5, `cfg_wdata[0]`=1), `dout` starts at 0 and toggles on every H-th tick. H is the half-period at address 4, `cfg_wdata[15:0]`, and H=0 acts as H=1.
- R7: When `enable` is low at a clock edge, `dout` is 0 after that edge. Raising `enable` again restarts from bit 0 and from the first repetition.
- R8: While `enable` is high, writes to addresses 1 to 5 are ignored, and that includes `len_err`. The pattern register (address 0, `cfg_wdata[31:0]`) accepts writes at any time, and a new pattern is used from the next bit that is sent.
- R9: After reset, `dout`, `loop_exit` and `len_err` are 0. All configuration also reads as 0 after reset: pattern mode, length code 0, count 0, delay 0, half-period 0, pattern 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | DW (32) | Configuration write data |
| enable | input | 1 | Run control; low stops the channel |
| tick | input | 1 | One-clock bit-rate strobe |
| dout | output | 1 | Serial pulse-train output |
| loop_exit | output | 1 | One-clock pulse when a finite loop count is exhausted |
| len_err | output | 1 | Last length write used the illegal code 1 |

## Verification
The bench aims at the tick where the final repetition ends. A design that is off by one at this point either clips the last bit or sends one extra repetition, and its `loop_exit` pulse lands on the wrong tick. Full-length code 0 and illegal code 1 are both run: a design that decodes them literally sends zero bits or one bit, or leaves `len_err` clear. The gap tests show whether the last bit is held for D bit times, or for D-1 or D+1. The run-time write tests show whether a design wrongly accepts a length or mode change mid-stream, or fails to pick up a new pattern. Square-wave runs with H of 0 and 1 expose a divider that stalls or never wraps.

// File: rtl/pt_pkg.sv
package pt_pkg;
  // Configuration register addresses
  localparam logic [2:0] ADDR_PAT  = 3'd0;
  localparam logic [2:0] ADDR_LEN  = 3'd1;
  localparam logic [2:0] ADDR_CNT  = 3'd2;
  localparam logic [2:0] ADDR_DLY  = 3'd3;
  localparam logic [2:0] ADDR_HALF = 3'd4;
  localparam logic [2:0] ADDR_MODE = 3'd5;

  typedef enum logic [1:0] {
    TR_IDLE  = 2'd0,
    TR_SHIFT = 2'd1,
    TR_GAP   = 2'd2,
    TR_STOP  = 2'd3
  } train_state_e;
endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs
  import pt_pkg::*;
#(
  parameter int W  = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          enable,
  output logic [W-1:0]  pattern,
  output logic [LW:0]   len_eff,
  output logic [CW-1:0] loop_cnt,
  output logic [CW-1:0] loop_dly,
  output logic [CW-1:0] half_per,
  output logic          sq_mode,
  output logic          len_err
);
  logic [W-1:0]  pat_q, pat_n;
  logic [LW-1:0] code_q, code_n;
  logic [CW-1:0] cnt_q, cnt_n, dly_q, dly_n, half_q, half_n;
  logic          mode_q, mode_n, err_q, err_n;
  logic          stopped_wr;

  assign stopped_wr = cfg_we & ~enable;

  always_comb begin
    pat_n  = pat_q;
    code_n = code_q;
    cnt_n  = cnt_q;
    dly_n  = dly_q;
    half_n = half_q;
    mode_n = mode_q;
    err_n  = err_q;
    if (cfg_we && cfg_addr == ADDR_PAT) pat_n = cfg_wdata[W-1:0];
    if (stopped_wr) begin
      unique case (cfg_addr)
        ADDR_LEN: begin
          code_n = cfg_wdata[LW-1:0];
          err_n  = (cfg_wdata[LW-1:0] == LW'(1));
        end
        ADDR_CNT:  cnt_n  = cfg_wdata[CW-1:0];
        ADDR_DLY:  dly_n  = cfg_wdata[CW-1:0];
        ADDR_HALF: half_n = cfg_wdata[CW-1:0];
        ADDR_MODE: mode_n = cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q  <= '0;
      code_q <= '0;
      cnt_q  <= '0;
      dly_q  <= '0;
      half_q <= '0;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pat_q  <= pat_n;
      code_q <= code_n;
      cnt_q  <= cnt_n;
      dly_q  <= dly_n;
      half_q <= half_n;
      mode_q <= mode_n;
      err_q  <= err_n;
    end
  end

  // Length decode: code 0 selects the full width, code 1 is forced to 2
  always_comb begin
    if (code_q == '0)             len_eff = (LW+1)'(W);
    else if (code_q == LW'(1))    len_eff = (LW+1)'(2);
    else                          len_eff = {1'b0, code_q};
  end

  assign pattern  = pat_q;
  assign loop_cnt = cnt_q;
  assign loop_dly = dly_q;
  assign half_per = half_q;
  assign sq_mode  = mode_q;
  assign len_err  = err_q;
endmodule

// File: rtl/pt_train.sv
module pt_train
  import pt_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16,
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [W-1:0]  pattern,
  input  logic [LW:0]   len_eff,
  input  logic [CW-1:0] loop_cnt,
  input  logic [CW-1:0] loop_dly,
  output logic          dout,
  output logic          loop_exit
);
  train_state_e  st_q, st_n;
  logic [LW:0]   idx_q, idx_n;
  logic [CW-1:0] loops_q, loops_n, gap_q, gap_n;
  logic          out_q, out_n, exit_n, exit_q;
  logic [CW-1:0] loops_inc;
  logic          last_rep;

  assign loops_inc = loops_q + CW'(1);
  assign last_rep  = (loop_cnt != '0) && (loops_inc == loop_cnt);

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    loops_n = loops_q;
    gap_n   = gap_q;
    out_n   = out_q;
    exit_n  = 1'b0;
    if (!run) begin
      st_n    = TR_IDLE;
      idx_n   = '0;
      loops_n = '0;
      gap_n   = '0;
      out_n   = 1'b0;
    end else if (tick) begin
      unique case (st_q)
        TR_IDLE: begin
          out_n   = pattern[0];
          idx_n   = (LW+1)'(1);
          loops_n = '0;
          st_n    = TR_SHIFT;
        end
        TR_SHIFT: begin
          if (idx_q < len_eff) begin
            out_n = pattern[idx_q[LW-1:0]];
            idx_n = idx_q + (LW+1)'(1);
          end else begin
            loops_n = loops_inc;
            if (last_rep) begin
              out_n  = 1'b0;
              exit_n = 1'b1;
              st_n   = TR_STOP;
            end else if (loop_dly == '0) begin
              out_n = pattern[0];
              idx_n = (LW+1)'(1);
            end else begin
              gap_n = CW'(1);
              st_n  = TR_GAP;
            end
          end
        end
        TR_GAP: begin
          if (gap_q == loop_dly) begin
            out_n = pattern[0];
            idx_n = (LW+1)'(1);
            st_n  = TR_SHIFT;
          end else begin
            gap_n = gap_q + CW'(1);
          end
        end
        TR_STOP: out_n = 1'b0;
        default: st_n = TR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TR_IDLE;
      idx_q   <= '0;
      loops_q <= '0;
      gap_q   <= '0;
      out_q   <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      loops_q <= loops_n;
      gap_q   <= gap_n;
      out_q   <= out_n;
      exit_q  <= exit_n;
    end
  end

  assign dout      = out_q;
  assign loop_exit = exit_q;
endmodule

// File: rtl/pt_square.sv
module pt_square #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] half_per,
  output logic          dout
);
  logic [CW-1:0] cnt_q, cnt_n, half_eff;
  logic          lvl_q, lvl_n;

  assign half_eff = (half_per == '0) ? CW'(1) : half_per;

  always_comb begin
    cnt_n = cnt_q;
    lvl_n = lvl_q;
    if (!run) begin
      cnt_n = '0;
      lvl_n = 1'b0;
    end else if (tick) begin
      if (cnt_q == half_eff - CW'(1)) begin
        cnt_n = '0;
        lvl_n = ~lvl_q;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      lvl_q <= lvl_n;
    end
  end

  assign dout = lvl_q;
endmodule

// File: rtl/pulse_chan.sv
module pulse_chan
  import pt_pkg::*;
#(
  parameter int W  = 32,   // pattern width, power of two
  parameter int DW = 32,   // write data width, at least W and CW
  parameter int CW = 16,   // loop count / delay / half-period width
  localparam int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          enable,
  input  logic          tick,
  output logic          dout,
  output logic          loop_exit,
  output logic          len_err
);
  logic [W-1:0]  pattern;
  logic [LW:0]   len_eff;
  logic [CW-1:0] loop_cnt, loop_dly, half_per;
  logic          sq_mode, tr_out, sq_out;

  pt_cfg_regs #(.W(W), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .enable(enable), .pattern(pattern),
    .len_eff(len_eff), .loop_cnt(loop_cnt), .loop_dly(loop_dly),
    .half_per(half_per), .sq_mode(sq_mode), .len_err(len_err)
  );

  pt_train #(.W(W), .CW(CW)) u_train (
    .clk(clk), .rst_n(rst_n), .run(enable & ~sq_mode), .tick(tick),
    .pattern(pattern), .len_eff(len_eff), .loop_cnt(loop_cnt),
    .loop_dly(loop_dly), .dout(tr_out), .loop_exit(loop_exit)
  );

  pt_square #(.CW(CW)) u_square (
    .clk(clk), .rst_n(rst_n), .run(enable & sq_mode), .tick(tick),
    .half_per(half_per), .dout(sq_out)
  );

  assign dout = sq_mode ? sq_out : tr_out;
endmodule

// File: rtl/pulse_chan_chk.sv
module pulse_chan_chk #(
  parameter int DW = 32,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic [DW-1:0] cfg_wdata,
  input logic          enable,
  input logic          tick,
  input logic          dout,
  input logic          loop_exit,
  input logic          len_err
);
  p_exit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |=> !loop_exit);
  p_exit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |-> !dout);
  p_exit_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |-> $past(tick));
  p_disable_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dout);
  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(dout));
  p_bad_len_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !enable && cfg_addr == 3'd1 && cfg_wdata[LW-1:0] == LW'(1)) |=> len_err);
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(len_err));
endmodule

bind pulse_chan pulse_chan_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .enable(enable), .tick(tick), .dout(dout),
  .loop_exit(loop_exit), .len_err(len_err)
);

// File: tb/pulse_chan_bench.sv
module pulse_chan_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, cfg_we, enable, tick;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        dout, loop_exit, len_err;

  int n_run, n_fail;

  pulse_chan u_pulse_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .enable(enable), .tick(tick), .dout(dout),
    .loop_exit(loop_exit), .len_err(len_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Model of the programmed configuration
  logic [31:0] m_pat;
  int m_code, m_cnt, m_dly, m_half;

  function automatic int len_of(input int code);
    if (code == 0) return 32;
    if (code == 1) return 2;
    return code;
  endfunction

  function automatic int stop_tick(input int L, input int cnt, input int dly);
    if (cnt == 0) return -1;
    return (cnt - 1) * (L + dly) + L;
  endfunction

  function automatic logic exp_train(input int k, input int L, input int cnt,
                                     input int dly, input logic [31:0] pat);
    int per, pos;
    per = L + dly;
    if (cnt != 0 && k >= stop_tick(L, cnt, dly)) return 1'b0;
    pos = k % per;
    if (pos < L) return pat[pos];
    return pat[L-1];
  endfunction

  function automatic logic exp_square(input int k, input int h);
    int he;
    he = (h == 0) ? 1 : h;
    return (((k + 1) / he) % 2) == 1;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic setup(input logic [31:0] pat, input int code, input int cnt,
                       input int dly, input int half, input bit sq);
    wr(3'd0, pat);  m_pat = pat;
    wr(3'd1, 32'(code)); m_code = code;
    wr(3'd2, 32'(cnt));  m_cnt = cnt;
    wr(3'd3, 32'(dly));  m_dly = dly;
    wr(3'd4, 32'(half)); m_half = half;
    wr(3'd5, {31'd0, sq});
  endtask

  // Runs a pattern-mode stream for n ticks and checks every bit
  task automatic run_train(input int n, input string req);
    int L, sk;
    L  = len_of(m_code);
    sk = stop_tick(L, m_cnt, m_dly);
    @(negedge clk) enable = 1'b1;
    for (int k = 0; k < n; k++) begin
      pulse_tick();
      check(dout, exp_train(k, L, m_cnt, m_dly, m_pat), req);
      check(loop_exit, (k == sk), {req, "/R4 exit"});
    end
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check(dout, 1'b0, "R7 stop");
  endtask

  task automatic run_square(input int n, input string req);
    @(negedge clk) enable = 1'b1;
    for (int k = 0; k < n; k++) begin
      pulse_tick();
      check(dout, exp_square(k, m_half), req);
    end
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check(dout, 1'b0, "R7 stop");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int L, sk;
    n_run = 0; n_fail = 0;
    void'($urandom(32'd24681));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    enable = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(dout, 1'b0, "R9 dout");
    check(loop_exit, 1'b0, "R9 loop_exit");
    check(len_err, 1'b0, "R9 len_err");
    // R9: default config is full length, forever
    m_pat = 32'h0; m_code = 0; m_cnt = 0; m_dly = 0; m_half = 0;
    run_train(40, "R9 default");

    // R2/R4: full 32-bit length, two repetitions back to back
    setup(32'hA5F0_3C96, 0, 2, 0, 0, 1'b0);
    run_train(70, "R2 full length");
    // R3: illegal length code 1 acts as 2 bits and flags
    setup(32'h0000_0001, 1, 3, 0, 0, 1'b0);
    check(len_err, 1'b1, "R3 flag set");
    run_train(10, "R3 length two");
    // R5: gap of 4 bit times with short pattern
    setup(32'h0000_0002, 2, 3, 4, 0, 1'b0);
    check(len_err, 1'b0, "R3 flag cleared");
    run_train(22, "R5 gap");
    // R4: forever mode keeps going
    setup(32'h0000_002D, 7, 0, 1, 0, 1'b0);
    run_train(100, "R4 forever");
    // R1: single repetition, odd length, R5 zero gap
    setup(32'h0000_1234, 13, 1, 0, 0, 1'b0);
    run_train(16, "R1 lsb first");
    // R6: square waves, half-period 3 and the 0 corner
    setup(32'hFFFF_FFFF, 5, 0, 0, 3, 1'b1);
    run_square(20, "R6 half3");
    wr(3'd4, 32'd0); m_half = 0;
    run_square(8, "R6 half0");
    wr(3'd4, 32'd1); m_half = 1;
    run_square(8, "R6 half1");

    // R8: locked config and live pattern rewrite while running
    setup(32'h0000_00F0, 8, 0, 0, 0, 1'b0);
    L = 8;
    @(negedge clk) enable = 1'b1;
    for (int k = 0; k < 40; k++) begin
      pulse_tick();
      check(dout, exp_train(k, L, 0, 0, m_pat), "R8 live");
      if (k == 11) begin
        wr(3'd1, 32'd1);           // ignored
        wr(3'd5, 32'd1);           // ignored
        wr(3'd0, 32'h0000_0055); m_pat = 32'h55;
        check(len_err, 1'b0, "R8 locked len_err");
      end
    end
    // R7: drop enable mid-stream, then restart at bit 0
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check(dout, 1'b0, "R7 disable");
    run_train(12, "R7 restart");

    // Random configurations
    for (int it = 0; it < 24; it++) begin
      logic [31:0] p;
      int c, n, d, h;
      p = $urandom;
      c = $urandom % 32;
      n = $urandom % 4;
      d = $urandom % 4;
      h = $urandom % 5;
      if (it % 4 == 3) begin
        setup(p, c, n, d, h, 1'b1);
        run_square(30, "R6 random");
      end else begin
        setup(p, c, n, d, h, 1'b0);
        check(len_err, (c == 1), "R3 random flag");
        L  = len_of(c);
        sk = stop_tick(L, n, d);
        run_train((n == 0) ? 3 * (L + d) : sk + 3, "R1 random");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule